// File: doc/BRIEF.md
# Fetch-Stage Loop Buffer

This block sits beside the fetch stage of an instruction pipeline. It keeps a short, contiguous run of the most recently fetched instruction words, each tagged by its word address. The run is a window described by a base address and a count of valid entries, and holds at most eight words by default. Every word that memory returns to the fetch stage is offered to the buffer. If that word continues the window, it is appended and the oldest word is dropped once the window is full. If it does not continue the window, the window restarts at that word.

When the pipeline redirects fetch to a branch target, the block checks in the same cycle whether the target lies inside the window. On a hit it supplies the instruction word at once and reports that no memory access is needed. It then keeps serving each sequential fetch from the window until it runs past the window's end. At that point it signals that memory must be used again. Short loops and short forward jumps can therefore run without touching main memory. A flush input empties the window in one cycle.

Storage slots are addressed by the low bits of the word address, so the slot for any address in the window is fixed. The lookup is a single subtraction and compare, with no search across the entries.

Top module: `loop_buffer`

## Requirements
- R1: After reset the window is empty: a redirect gives hit_o=0 and mem_fetch_o=1.
- R2: A fill whose address equals base+count, with count nonzero, is appended. When count is already DEPTH (8), the base advances by one, so the oldest word is no longer a hit.
- R3: A fill into an empty window, or one whose address is not base+count, restarts the window with base equal to that address and count equal to one.
- R4: A redirect hits when (target-base) modulo 2^ADDR_W is below count. In that same cycle hit_o=1, mem_fetch_o=0, and instr_o is the word last filled at that address.
- R5: Whenever hit_o=0, instr_o is zero. A redirect that misses gives mem_fetch_o=1.
- R6: After a redirect hit, each cycle with seq_en_i=1 looks up the next address in order (target+1, target+2, and so on). While the looked-up address is in the window, that word is supplied. The first address outside the window gives hit_o=0 and mem_fetch_o=1, and ends serving from the buffer.
- R7: A seq_en_i cycle while the block is not serving from the buffer gives hit_o=0 and mem_fetch_o=1.
- R8: When redir_valid_i and seq_en_i are both high, the redirect alone decides the lookup.
- R9: flush_i empties the window by the next cycle and stops serving; a fill in the same cycle is dropped. Lookups in the flush cycle itself use the state before the flush.
- R10: In a cycle with neither redir_valid_i nor seq_en_i, hit_o=0 and mem_fetch_o=0.
- R11: Address arithmetic wraps modulo 2^ADDR_W, so a window may span the top address and address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| fill_valid_i | input | 1 | A word from memory is offered to the buffer |
| fill_addr_i | input | ADDR_W | Word address of the offered word |
| fill_instr_i | input | INSTR_W | Offered instruction word |
| seq_en_i | input | 1 | Fetch stage advances sequentially this cycle |
| redir_valid_i | input | 1 | Fetch is redirected to a branch target |
| redir_target_i | input | ADDR_W | Branch target word address |
| hit_o | output | 1 | The requested word is supplied from the buffer |
| instr_o | output | INSTR_W | Supplied word, zero when no hit |
| mem_fetch_o | output | 1 | The requested word must come from memory |

## Verification
The bench runs long, mostly contiguous fill streams. Some of these overflow the window, which separates correct oldest-entry eviction from plain appending. Others jump to unrelated addresses, which exposes a missing window restart. Redirect targets are placed around both ends of the window, so off-by-one errors in the lower and upper bounds of the hit compare show up as wrong hit or wrong data. Sequential runs after a hit, combined redirect and sequential cycles, flushes, and a window that wraps through address zero each test a different part of the stream and window logic. Every case is compared against a model built from the rules above.

// File: rtl/lb_pkg.sv
// Package: shared types for the fetch-stage loop buffer.
// Assumes: nothing beyond standard SystemVerilog.
package lb_pkg;
    // Whether fetch is being served from the buffer or from memory.
    typedef enum logic {
        LB_MEM    = 1'b0,
        LB_STREAM = 1'b1
    } lb_mode_e;
endpackage

// File: rtl/lb_store.sv
// Module: lb_store
// Holds DEPTH instruction words with one write port and one combinational read port.
// Assumes: DEPTH is a power of two; the caller picks the slot from the low address bits.
module lb_store #(
    parameter int DEPTH   = 8,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [INSTR_W-1:0] rd_data
);
    logic [INSTR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the offered word when this slot is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    // Read the addressed slot without a clock delay.
    always_comb begin
        rd_data = slot_q[rd_idx];
    end
endmodule

// File: rtl/lb_window.sv
// Module: lb_window
// Tracks the base address and valid count of the buffered run, applies the fill
// policy (append, evict oldest, or restart) and answers one lookup per cycle.
// Assumes: ADDR_W is wider than CNT_W; lookups see the state before this cycle's update.
module lb_window #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W-1:0] look_off;
    logic              contig;

    // Decide whether the offered word extends the current run.
    always_comb begin
        end_addr = base_q + ADDR_W'(cnt_q);
        contig   = (cnt_q != '0) && (fill_addr == end_addr);
    end

    // Update the base and count: flush, append, evict oldest, or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            cnt_q  <= '0;
        end else if (fill_valid) begin
            if (!contig) begin
                base_q <= fill_addr;
                cnt_q  <= CNT_W'(1);
            end else if (cnt_q == FULL) begin
                base_q <= base_q + ADDR_W'(1);
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Check residency with one wrapping subtract and one compare.
    always_comb begin
        look_off = look_addr - base_q;
        look_hit = (look_off < ADDR_W'(cnt_q));
    end

    // Each address owns a fixed slot given by its low bits.
    always_comb begin
        wr_en  = fill_valid && !flush;
        wr_idx = fill_addr[IDX_W-1:0];
    end
endmodule

// File: rtl/lb_stream.sv
// Module: lb_stream
// Follows sequential fetch after a redirect hit. It holds the next address to
// look up and drops back to memory fetch at the first miss.
// Assumes: redirect takes priority over sequential fetch; flush beats both.
module lb_stream #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_target,
    input  logic              seq_en,
    input  logic              look_hit,
    output logic              serving,
    output logic [ADDR_W-1:0] cur_addr
);
    import lb_pkg::*;

    lb_mode_e          mode_q;
    logic [ADDR_W-1:0] cur_q;

    // Step the serving state and the next sequential address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LB_MEM;
            cur_q  <= '0;
        end else if (flush) begin
            mode_q <= LB_MEM;
        end else if (redir_valid) begin
            mode_q <= look_hit ? LB_STREAM : LB_MEM;
            cur_q  <= redir_target + ADDR_W'(1);
        end else if (seq_en && (mode_q == LB_STREAM)) begin
            if (look_hit) begin
                cur_q  <= cur_q + ADDR_W'(1);
            end else begin
                mode_q <= LB_MEM;
            end
        end
    end

    // Expose the state to the top.
    always_comb begin
        serving  = (mode_q == LB_STREAM);
        cur_addr = cur_q;
    end
endmodule

// File: rtl/loop_buffer.sv
// Module: loop_buffer (top)
// Fetch-stage loop buffer: keeps the latest contiguous run of fetched words and
// answers branch targets and the sequential fetches after them from that run.
// Assumes: DEPTH is a power of two; words are word-addressed; outputs are
// combinational responses to this cycle's request.
module loop_buffer #(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 32,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               fill_valid_i,
    input  logic [ADDR_W-1:0]  fill_addr_i,
    input  logic [INSTR_W-1:0] fill_instr_i,
    input  logic               seq_en_i,
    input  logic               redir_valid_i,
    input  logic [ADDR_W-1:0]  redir_target_i,
    output logic               hit_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic               mem_fetch_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic              look_hit;
    logic [ADDR_W-1:0] look_addr;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [INSTR_W-1:0] rd_data;
    logic              serving;
    logic [ADDR_W-1:0] cur_addr;
    logic              buf_req;

    // A redirect looks up its target; otherwise the stream's next address is used.
    always_comb begin
        look_addr = redir_valid_i ? redir_target_i : cur_addr;
        buf_req   = redir_valid_i || (seq_en_i && serving);
    end

    lb_window #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .fill_valid (fill_valid_i),
        .fill_addr  (fill_addr_i),
        .look_addr  (look_addr),
        .look_hit   (look_hit),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx)
    );

    lb_store #(
        .DEPTH   (DEPTH),
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (fill_instr_i),
        .rd_idx  (look_addr[IDX_W-1:0]),
        .rd_data (rd_data)
    );

    lb_stream #(
        .ADDR_W (ADDR_W)
    ) u_stream (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush_i),
        .redir_valid  (redir_valid_i),
        .redir_target (redir_target_i),
        .seq_en       (seq_en_i),
        .look_hit     (look_hit),
        .serving      (serving),
        .cur_addr     (cur_addr)
    );

    // Form the response: supply on a hit, request memory on any unmet fetch.
    always_comb begin
        hit_o       = buf_req && look_hit;
        mem_fetch_o = (redir_valid_i || seq_en_i) && !hit_o;
        instr_o     = hit_o ? rd_data : '0;
    end
endmodule

// File: rtl/lb_checker.sv
// Module: lb_checker
// Port-level properties of the loop buffer, attached to every instance by bind.
// Assumes: the same synchronous active-low reset as the design.
module lb_checker #(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               seq_en_i,
    input logic               redir_valid_i,
    input logic               hit_o,
    input logic [INSTR_W-1:0] instr_o,
    input logic               mem_fetch_o
);
    AST_NO_HIT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !hit_o); // R9
    AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (instr_o == '0)); // R5
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !mem_fetch_o); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_i && !seq_en_i) |-> (!hit_o && !mem_fetch_o)); // R10
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_i || seq_en_i) |-> (hit_o || mem_fetch_o)); // R7
    AST_STREAM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en_i && !redir_valid_i && mem_fetch_o) |=> (redir_valid_i || !hit_o)); // R6
endmodule

bind loop_buffer lb_checker #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) u_lb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .seq_en_i      (seq_en_i),
    .redir_valid_i (redir_valid_i),
    .hit_o         (hit_o),
    .instr_o       (instr_o),
    .mem_fetch_o   (mem_fetch_o)
);

// File: tb/tb_loop_buffer.sv
module tb_loop_buffer;
    localparam int AW = 16;
    localparam int IW = 32;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          fill_valid_i = 1'b0;
    logic [AW-1:0] fill_addr_i = '0;
    logic [IW-1:0] fill_instr_i = '0;
    logic          seq_en_i = 1'b0;
    logic          redir_valid_i = 1'b0;
    logic [AW-1:0] redir_target_i = '0;
    logic          hit_o;
    logic [IW-1:0] instr_o;
    logic          mem_fetch_o;

    int total = 0;
    int bad = 0;

    // Reference model state, built from the requirements.
    logic [IW-1:0] m_data [DP];
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    logic          m_serv = 1'b0;
    logic [AW-1:0] m_cur = '0;

    always #5 clk = ~clk;

    loop_buffer #(.ADDR_W(AW), .INSTR_W(IW), .DEPTH(DP)) dut (.*);

    function automatic logic m_in_win(input logic [AW-1:0] a);
        logic [AW-1:0] off;
        off = a - m_base;
        return int'(off) < m_cnt;
    endfunction

    task automatic chk(input string tag, input string what, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check the combinational response, then advance the model.
    task automatic step(input logic r, input logic [AW-1:0] t, input logic s,
                        input logic fv, input logic [AW-1:0] fa, input logic [IW-1:0] fd,
                        input logic fl, input string tag);
        logic [AW-1:0] look;
        logic          ehit;
        logic          emf;
        logic [IW-1:0] edat;
        @(negedge clk);
        redir_valid_i = r; redir_target_i = t; seq_en_i = s;
        fill_valid_i = fv; fill_addr_i = fa; fill_instr_i = fd; flush_i = fl;
        #1;
        look = r ? t : m_cur;
        ehit = (r || (s && m_serv)) && m_in_win(look);
        emf  = (r || s) && !ehit;
        edat = ehit ? m_data[look[2:0]] : '0;
        chk(tag, "hit", IW'(hit_o), IW'(ehit));
        chk(tag, "mem_fetch", IW'(mem_fetch_o), IW'(emf));
        chk(tag, "instr", instr_o, edat);
        @(posedge clk);
        if (fl) begin
            m_serv = 1'b0;
        end else if (r) begin
            m_serv = ehit;
            m_cur  = t + 1'b1;
        end else if (s && m_serv) begin
            if (ehit) m_cur = m_cur + 1'b1;
            else      m_serv = 1'b0;
        end
        if (fl) begin
            m_cnt = 0;
        end else if (fv) begin
            m_data[fa[2:0]] = fd;
            if (m_cnt != 0 && fa == m_base + AW'(m_cnt)) begin
                if (m_cnt == DP) m_base = m_base + 1'b1;
                else             m_cnt = m_cnt + 1;
            end else begin
                m_base = fa;
                m_cnt  = 1;
            end
        end
    endtask

    task automatic fill(input logic [AW-1:0] a, input string tag);
        step(1'b0, '0, 1'b0, 1'b1, a, {a, ~a}, 1'b0, tag);
    endtask

    task automatic redir(input logic [AW-1:0] a, input string tag);
        step(1'b1, a, 1'b0, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic seq(input string tag);
        step(1'b0, '0, 1'b1, 1'b0, '0, '0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DP; i++) m_data[i] = '0;
        void'($urandom(32'h5eed_1b0f));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // Reset state and idle behaviour
        step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, "R10");
        redir(16'h0000, "R1");
        seq("R7");
        // Build a short run and hit inside it
        for (int a = 'h100; a < 'h105; a++) fill(AW'(a), "R3 R2");
        redir(16'h0102, "R4");
        seq("R6");
        seq("R6");
        seq("R6");
        seq("R7");
        redir(16'h00FF, "R5");
        redir(16'h0105, "R5");
        // Overflow: oldest word dropped
        for (int a = 'h105; a < 'h10C; a++) fill(AW'(a), "R2");
        redir(16'h0103, "R2");
        redir(16'h0104, "R2");
        redir(16'h010B, "R2");
        // Non-contiguous fill restarts
        fill(16'h0200, "R3");
        redir(16'h0104, "R3");
        redir(16'h0200, "R3");
        // Redirect wins over sequential fetch
        step(1'b1, 16'h0200, 1'b1, 1'b0, '0, '0, 1'b0, "R8");
        step(1'b1, 16'h0300, 1'b1, 1'b0, '0, '0, 1'b0, "R8");
        // Flush, with a fill in the same cycle
        redir(16'h0200, "R9");
        step(1'b0, '0, 1'b1, 1'b1, 16'h0201, 32'hDEAD_BEEF, 1'b1, "R9");
        redir(16'h0200, "R9");
        redir(16'h0201, "R9");
        // Window across the top address
        fill(16'hFFFE, "R11");
        fill(16'hFFFF, "R11");
        fill(16'h0000, "R11");
        fill(16'h0001, "R11");
        redir(16'hFFFF, "R11");
        seq("R11");
        seq("R11");
        seq("R11");
        redir(16'hFFFD, "R11");
        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic          r;
            logic          s;
            logic          fv;
            logic          fl;
            logic [AW-1:0] t;
            logic [AW-1:0] fa;
            r  = ($urandom % 100) < 15;
            s  = ($urandom % 100) < 50;
            fv = ($urandom % 100) < 50;
            fl = ($urandom % 100) < 2;
            t  = m_base + AW'($urandom % 13) - AW'(2);
            fa = (($urandom % 100) < 85) ? (m_base + AW'(m_cnt)) : AW'($urandom);
            step(r, t, s, fv, fa, $urandom, fl, "R2 R4 R6");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule